// File: doc/BRIEF.md
# Function-Code ALU

This block is a 32-bit integer arithmetic and logic unit steered by a single 5-bit function code. Three datapaths share one output selection, and all three see the same two operands `A` and `B`:

- an adder that either adds or subtracts;
- a barrel shifter that moves `B` by the low five bits of `A`;
- a per-bit Boolean unit.

The same adder also answers signed and unsigned less-than questions. It does this by subtracting and turning its flags into a single result bit.

The result and the four condition flags (zero, negative, overflow, carry) are captured in output registers. An answer appears one clock after its operands and code are presented. A synchronous active-high reset clears the registers. The function code is split into fields, packed as `{sub, bsel[1:0], shft, math}` from bit 4 down to bit 0:

- `math` chooses the arithmetic/compare side or the shift/Boolean side.
- `shft` separates shifting from the other function on that side.
- `bsel` picks the Boolean function, or the kind of shift.
- `sub` chooses subtraction.

Top module: `fcode_alu`

## Requirements
- R1: All outputs are registered. Operands and code presented before a rising edge appear on the outputs after that edge. While `rst` is high at an edge, the outputs become result 0, `z_o`=1, `n_o`=`v_o`=`c_o`=0.
- R2: With `math`=1 and `shft`=0 (codes 0x01 and 0x11), `sub`=0 gives A+B mod 2^32 and `sub`=1 gives A-B mod 2^32.
- R3: With `sub`=1, `shft`=1 and `math`=1, the result is 1 in bit 0, with all other bits 0, when A is less than B. `bsel[0]`=0 compares as signed (code 0x13 or 0x1B). `bsel[0]`=1 compares as unsigned (code 0x17 or 0x1F). Otherwise the result is 0.
- R4: With `math`=0 and `shft`=1, B is shifted by A[4:0], and bits A[31:5] have no effect. `bsel`=00 shifts left with zero fill (0x02). `bsel`=10 shifts right with zero fill (0x0A). `bsel`=11 shifts right and copies B[31] into the vacated bits (0x0E).
- R5: With `math`=0 and `shft`=0, `bsel` selects the bitwise function: 00 AND (0x00), 01 OR (0x04), 10 XOR (0x08), 11 NOR (0x0C).
- R6: The `sub` bit has no effect on the result of shift and Boolean codes (for example, 0x12 equals 0x02 and 0x10 equals 0x00).
- R7: For every code, `z_o` is 1 exactly when the registered result is zero.
- R8: For add, subtract and compare codes, the flags come from the adder. `n_o` is bit 31 of the sum or difference. `c_o` is the carry out of bit 31, computed as A + ~B + 1 when subtracting. `v_o` is 1 on two's-complement overflow.
- R9: The codes with no assigned function give a result of 0. These are `math`=1, `shft`=1, `sub`=0 (0x03, 0x07, 0x0B, 0x0F), and `math`=0, `shft`=1, `bsel`=01 (0x06, 0x16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 32 | Operand A; shift amount in bits 4:0 for shift codes |
| b_i | input | 32 | Operand B; value shifted for shift codes |
| fn_i | input | 5 | Function code {sub, bsel[1:0], shft, math} |
| res_o | output | 32 | Registered result |
| z_o | output | 1 | Result-is-zero flag |
| n_o | output | 1 | Adder sign flag |
| v_o | output | 1 | Adder signed-overflow flag |
| c_o | output | 1 | Adder carry-out flag |

## Verification
The in-module assertions check a fixed set of properties one cycle after each code is presented. They cover the sums and differences of the add and subtract codes, and that compare results are confined to bit 0. They also cover unsigned less-than, the NOR function, the zero result of unassigned arithmetic codes, the zero flag's agreement with the result, and the reset values.

The remaining behaviour can only be shown by the bench's scenarios, which run every one of the 32 codes over chosen operand pairs. This includes the signed comparison, every shift direction and fill at the distance extremes, and that the `sub` bit and A's upper bits are ignored. It also includes the exact overflow and carry flags, reset arriving while an operation is in flight, and the one-cycle registered latency.

// File: rtl/fcode_alu_pkg.sv
package fcode_alu_pkg;

  // Function code, bit 4 down to bit 0
  typedef struct packed {
    logic       sub;
    logic [1:0] bsel;
    logic       shft;
    logic       math;
  } fcode_t;

  localparam logic [1:0] BSEL_AND  = 2'b00;
  localparam logic [1:0] BSEL_OR   = 2'b01;
  localparam logic [1:0] BSEL_XOR  = 2'b10;
  localparam logic [1:0] BSEL_NOR  = 2'b11;
  localparam logic [1:0] BSEL_SHNO = 2'b01; // no shift assigned

endpackage

// File: rtl/fcode_alu_addsub.sv
module fcode_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         neg,
  output logic         ovf,
  output logic         cout
);

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  assign b_eff = op_b ^ {W{do_sub}};
  assign wide  = {1'b0, op_a} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
  assign sum   = wide[W-1:0];
  assign cout  = wide[W];
  assign neg   = wide[W-1];
  // Overflow when both addends share a sign that the sum does not
  assign ovf   = (op_a[W-1] == b_eff[W-1]) && (wide[W-1] != op_a[W-1]);

endmodule

// File: rtl/fcode_alu_shift.sv
module fcode_alu_shift #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [SW-1:0] amt,
  input  logic          go_right,
  input  logic          arith,
  output logic [W-1:0]  shifted
);

  logic [W-1:0] st [SW+1];
  logic         fill;

  assign fill  = arith & val[W-1];
  assign st[0] = val;

  // One stage per amount bit, each moving by a power of two
  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int D = 1 << k;
    assign st[k+1] = !amt[k]  ? st[k] :
                     go_right ? {{D{fill}}, st[k][W-1:D]} :
                                {st[k][W-1-D:0], {D{1'b0}}};
  end

  assign shifted = st[SW];

endmodule

// File: rtl/fcode_alu_logic.sv
module fcode_alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   bsel,
  output logic [W-1:0] q
);

  import fcode_alu_pkg::*;

  // Bit slices are independent: a 4:1 choice per position
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q[i] = (bsel == BSEL_AND) ? (op_a[i] & op_b[i]) :
                  (bsel == BSEL_OR)  ? (op_a[i] | op_b[i]) :
                  (bsel == BSEL_XOR) ? (op_a[i] ^ op_b[i]) :
                                       ~(op_a[i] | op_b[i]);
  end

endmodule

// File: rtl/fcode_alu.sv
module fcode_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [4:0]   fn_i,
  output logic [W-1:0] res_o,
  output logic         z_o,
  output logic         n_o,
  output logic         v_o,
  output logic         c_o
);

  import fcode_alu_pkg::*;

  localparam int SW = $clog2(W);

  fcode_t       f;
  logic [W-1:0] sum, sh_out, lg_out, res_d;
  logic         neg, ovf, cout, lt_bit;

  assign f = fcode_t'(fn_i);

  fcode_alu_addsub #(.W(W)) u_addsub (
    .op_a(a_i), .op_b(b_i), .do_sub(f.sub),
    .sum(sum), .neg(neg), .ovf(ovf), .cout(cout)
  );

  fcode_alu_shift #(.W(W), .SW(SW)) u_shift (
    .val(b_i), .amt(a_i[SW-1:0]), .go_right(f.bsel[1]), .arith(f.bsel[0]),
    .shifted(sh_out)
  );

  fcode_alu_logic #(.W(W)) u_logic (
    .op_a(a_i), .op_b(b_i), .bsel(f.bsel), .q(lg_out)
  );

  // Signed less-than from N xor V, unsigned from a clear carry
  assign lt_bit = f.bsel[0] ? ~cout : (neg ^ ovf);

  always_comb begin
    res_d = '0;
    if (f.math) begin
      if (!f.shft)    res_d = sum;
      else if (f.sub) res_d = {{(W-1){1'b0}}, lt_bit};
    end else if (f.shft) begin
      if (f.bsel != BSEL_SHNO) res_d = sh_out;
    end else begin
      res_d = lg_out;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      z_o   <= 1'b1;
      n_o   <= 1'b0;
      v_o   <= 1'b0;
      c_o   <= 1'b0;
    end else begin
      res_o <= res_d;
      z_o   <= (res_d == '0);
      n_o   <= neg;
      v_o   <= ovf;
      c_o   <= cout;
    end
  end

  // Assertions
  p_reset_vals_r1: assert property (@(posedge clk)
    rst |=> (res_o == '0 && z_o && !n_o && !v_o && !c_o));

  p_add_r2: assert property (@(posedge clk) disable iff (rst)
    (fn_i == 5'h01) |=> (res_o == $past(a_i) + $past(b_i)));

  p_sub_r2: assert property (@(posedge clk) disable iff (rst)
    (fn_i == 5'h11) |=> (res_o == $past(a_i) - $past(b_i)));

  p_cmp_narrow_r3: assert property (@(posedge clk) disable iff (rst)
    (fn_i[4] && fn_i[1] && fn_i[0]) |=> (res_o[W-1:1] == '0));

  p_ltu_r3: assert property (@(posedge clk) disable iff (rst)
    (fn_i[4] && fn_i[2] && fn_i[1] && fn_i[0])
      |=> (res_o[0] == ($past(a_i) < $past(b_i))));

  p_nor_r5: assert property (@(posedge clk) disable iff (rst)
    (fn_i[3:0] == 4'b1100) |=> (res_o == ~($past(a_i) | $past(b_i))));

  p_undef_r9: assert property (@(posedge clk) disable iff (rst)
    (!fn_i[4] && fn_i[1] && fn_i[0]) |=> (res_o == '0));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
    z_o == (res_o == '0));

endmodule

// File: tb/fcode_alu_tb.sv
module fcode_alu_tb;

  localparam int W          = 32;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic [4:0]   fn = '0;
  logic [W-1:0] res_o;
  logic         z_o, n_o, v_o, c_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  fcode_alu #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .fn_i(fn),
    .res_o(res_o), .z_o(z_o), .n_o(n_o), .v_o(v_o), .c_o(c_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {fn, a, b, expected result}
  localparam logic [100:0] VEC [20] = '{
    {5'h01, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'h01, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000},
    {5'h11, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE},
    {5'h11, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF},
    {5'h13, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},
    {5'h17, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
    {5'h13, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000},
    {5'h17, 32'h0000_0003, 32'h0000_0009, 32'h0000_0001},
    {5'h02, 32'h0000_0004, 32'h0000_00F1, 32'h0000_0F10},
    {5'h0A, 32'h0000_0024, 32'h8000_0000, 32'h0800_0000},
    {5'h0E, 32'h0000_001F, 32'h8000_0000, 32'hFFFF_FFFF},
    {5'h0E, 32'h0000_0001, 32'hFFFF_FFEC, 32'hFFFF_FFF6},
    {5'h00, 32'h0000_00AE, 32'h0000_000F, 32'h0000_000E},
    {5'h04, 32'h0000_00AE, 32'h0000_000F, 32'h0000_00AF},
    {5'h08, 32'h0000_00AE, 32'h0000_000F, 32'h0000_00A1},
    {5'h0C, 32'h0000_00AE, 32'h0000_000F, 32'hFFFF_FF50},
    {5'h03, 32'h0000_0003, 32'h0000_0004, 32'h0000_0000},
    {5'h06, 32'h0000_0001, 32'h0000_0007, 32'h0000_0000},
    {5'h12, 32'h0000_0001, 32'h0000_0003, 32'h0000_0006},
    {5'h10, 32'h0000_00FF, 32'h0000_003C, 32'h0000_003C}
  };

  localparam logic [63:0] PAIRS [8] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'h0000_0001},
    {32'h7FFF_FFFF, 32'h7FFF_FFFF},
    {32'h8000_0000, 32'h8000_0000},
    {32'h1234_5678, 32'h9ABC_DEF0},
    {32'h0000_001F, 32'hF0F0_F0F0},
    {32'h0000_0020, 32'hDEAD_BEEF},
    {32'hA5A5_A5A5, 32'hA5A5_A5A5}
  };

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [4:0] f);
    if (f[0] && f[1])  return f[4] ? "R3" : "R9";
    if (f[0])          return "R2";
    if (f[1])          return (f[3:2] == 2'b01) ? "R9" : (f[4] ? "R6" : "R4");
    return f[4] ? "R6" : "R5";
  endfunction

  // Reference: returns {c, v, n, z, result}
  function automatic logic [35:0] model(input logic [4:0] f,
                                        input logic [31:0] x, input logic [31:0] y);
    logic [32:0] w;
    logic [31:0] r;
    logic        v;
    if (f[4]) begin
      w = {1'b0, x} + {1'b0, ~y} + 33'd1;
      v = (x[31] != y[31]) && (w[31] != x[31]);
    end else begin
      w = {1'b0, x} + {1'b0, y};
      v = (x[31] == y[31]) && (w[31] != x[31]);
    end
    r = '0;
    if (f[0]) begin
      if (!f[1])     r = w[31:0];
      else if (f[4]) r = f[2] ? {31'd0, x < y} : {31'd0, $signed(x) < $signed(y)};
    end else if (f[1]) begin
      case (f[3:2])
        2'b00:   r = y << x[4:0];
        2'b10:   r = y >> x[4:0];
        2'b11:   r = $unsigned($signed(y) >>> x[4:0]);
        default: r = '0;
      endcase
    end else begin
      case (f[3:2])
        2'b00:   r = x & y;
        2'b01:   r = x | y;
        2'b10:   r = x ^ y;
        default: r = ~(x | y);
      endcase
    end
    return {w[32], v, w[31], (r == 0), r};
  endfunction

  task automatic apply_check(input logic [4:0] f, input logic [31:0] x, input logic [31:0] y);
    logic [35:0] e;
    e = model(f, x, y);
    @(negedge clk);
    fn = f; a = x; b = y;
    @(negedge clk);
    chk(req_of(f), $sformatf("result fn=%h", f), res_o, e[31:0]);
    chk("R7", $sformatf("zero fn=%h", f), {31'd0, z_o}, {31'd0, e[32]});
    if (f[0] && (!f[1] || f[4])) begin
      chk("R8", $sformatf("neg fn=%h", f),  {31'd0, n_o}, {31'd0, e[33]});
      chk("R8", $sformatf("ovf fn=%h", f),  {31'd0, v_o}, {31'd0, e[34]});
      chk("R8", $sformatf("cout fn=%h", f), {31'd0, c_o}, {31'd0, e[35]});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "reset result", res_o, '0);
    chk("R1", "reset flags", {28'd0, z_o, n_o, v_o, c_o}, 32'h8);
    rst = 1'b0;

    // Table walk: fixed expected result plus full model comparison
    for (int i = 0; i < 20; i++) begin
      logic [100:0] v;
      v = VEC[i];
      apply_check(v[100:96], v[95:64], v[63:32]);
      chk(req_of(v[100:96]), $sformatf("table row %0d", i), res_o, v[31:0]);
    end

    // Every code over every operand pair (R2..R9, R6 via codes with sub set)
    for (int c = 0; c < 32; c++) begin
      for (int p = 0; p < 8; p++) begin
        apply_check(c[4:0], PAIRS[p][63:32], PAIRS[p][31:0]);
      end
    end

    // R4: upper bits of A ignored for the shift distance
    apply_check(5'h02, 32'hFFFF_FFE3, 32'h0000_0001);
    chk("R4", "upper A bits ignored", res_o, 32'h0000_0008);

    // R1: registered latency, output holds until the next edge
    apply_check(5'h01, 32'd1, 32'd1);
    fn = 5'h01; a = 32'd3; b = 32'd3;
    #1;
    chk("R1", "output held before edge", res_o, 32'd2);
    @(negedge clk);
    chk("R1", "output after edge", res_o, 32'd6);

    // R1: reset while an operation is presented
    fn = 5'h01; a = 32'd5; b = 32'd6; rst = 1'b1;
    @(negedge clk);
    chk("R1", "reset over add", res_o, '0);
    chk("R1", "reset zero flag", {31'd0, z_o}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "resume after reset", res_o, 32'd11);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule